// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block produces the address-strobe and data-strobe waveform for one read or write access to a removable card. It serves both the card's common-memory space and its I/O space. A host-side request pulse starts an access. The sequencer asserts the address strobe first. It waits through a programmable setup phase, then asserts the data strobe for a programmable access phase. It releases the data strobe and keeps the address strobe low through a programmable hold phase. It then releases the address strobe and pulses `done`.

Each space has its own configuration word. The word holds three 8-bit phase fields, each written as the desired length minus one, and a bus-width bit. A space-select input picks which word governs the access being started. The chosen word is captured when the access begins, so software may rewrite it while an access is in flight without disturbing that access. The width bit of the selected space is presented on `xfer_wide` so the datapath knows whether to move 8 or 16 bits.

Top module: `card_strobe_seq`

## Requirements
- R1: After reset both strobes are high, `done` and `busy` are low, `xfer_wide` is 0, and both configuration words are zero. An access started with reset-state configuration therefore has setup, access and hold phases of exactly 1 cycle each.
- R2: After the address strobe goes low, the data strobe stays high for exactly setup+1 clock cycles.
- R3: The data strobe stays low for exactly access+1 clock cycles.
- R4: After the data strobe goes high, the address strobe stays low for exactly hold+1 further cycles.
- R5: The data strobe is low only while the address strobe is low. The address strobe falls before the data strobe falls, and the data strobe rises before the address strobe rises.
- R6: `done` is high for exactly one cycle, the same cycle in which the address strobe returns high, and `busy` is low on the following cycle.
- R7: `req_space` = 0 selects the common-memory word and `req_space` = 1 selects the I/O word for the access being started.
- R8: `xfer_wide` shows the width bit (bit 31) of the selected word during the access: 0 means 8-bit and 1 means 16-bit.
- R9: A request that arrives while an access is in progress is ignored and starts no later access.
- R10: The configuration is captured when an access starts. A write to the selected word during the access does not change that access but applies to the next one.
- R11: Configuration word layout: setup in bits 7:0, access in bits 15:8, hold in bits 23:16, width in bit 31. Bits 30:24 have no effect. `cfg_space` picks the word that `cfg_we` writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_space | input | 1 | Word written: 0 common memory, 1 I/O |
| cfg_wdata | input | 32 | Configuration word to write |
| req | input | 1 | Access request, taken only when idle |
| req_space | input | 1 | Space of the requested access: 0 common memory, 1 I/O |
| addr_strobe_n | output | 1 | Active-low address strobe |
| data_strobe_n | output | 1 | Active-low data strobe |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an access is in progress |
| xfer_wide | output | 1 | Bus width of the current access, 1 = 16-bit |

## Verification
The address strobe falls on the first clock edge that samples `req` while the block is idle. The data strobe falls setup+1 edges later, rises access+1 edges after that, and the address strobe rises together with `done` hold+1 edges after the data strobe rises. `busy` drops one edge after that. The monitor samples every output at the falling clock edge. It measures each phase by counting the falling edges on which the strobe pair holds a given state, then compares the three counts and the width bit against the queue entry that the driver pushed when it issued the request. Each phase count is therefore checked against its field value plus one, independent of the absolute start time. A strobe activity with an empty queue, or a `done` outside the address-strobe release cycle, is reported as a failure.

// File: rtl/card_strobe_pkg.sv
package card_strobe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACCESS,
    PH_HOLD,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/card_strobe_regs.sv
module card_strobe_regs #(
  parameter int FIELD_W = 8,
  parameter int CFG_W   = 32,
  parameter int NSPACE  = 2,
  localparam int SEL_W  = (NSPACE > 1) ? $clog2(NSPACE) : 1,
  localparam int KEEP_W = 3*FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_space,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [SEL_W-1:0]   rd_space,
  output logic [FIELD_W-1:0] setup_f,
  output logic [FIELD_W-1:0] access_f,
  output logic [FIELD_W-1:0] hold_f,
  output logic               wide_f
);
  // width bit stored at the top, three fields packed below it
  logic [KEEP_W-1:0] bank_q [NSPACE];
  logic [KEEP_W-1:0] wr_word;
  logic [KEEP_W-1:0] rd_word;
  logic              unused_rsvd;

  assign wr_word     = {cfg_wdata[CFG_W-1], cfg_wdata[3*FIELD_W-1:0]};
  assign unused_rsvd = ^cfg_wdata[CFG_W-2:3*FIELD_W];

  for (genvar s = 0; s < NSPACE; s++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[s] <= '0;
      end else if (cfg_we && (cfg_space == SEL_W'(s))) begin
        bank_q[s] <= wr_word;
      end
    end
  end

  assign rd_word  = bank_q[rd_space];
  assign setup_f  = rd_word[FIELD_W-1:0];
  assign access_f = rd_word[2*FIELD_W-1:FIELD_W];
  assign hold_f   = rd_word[3*FIELD_W-1:2*FIELD_W];
  assign wide_f   = rd_word[KEEP_W-1];
endmodule

// File: rtl/card_phase_counter.sv
module card_phase_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/card_strobe_fsm.sv
module card_strobe_fsm
  import card_strobe_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [FIELD_W-1:0] setup_f,
  input  logic [FIELD_W-1:0] access_f,
  input  logic [FIELD_W-1:0] hold_f,
  input  logic               wide_f,
  input  logic               cnt_zero,
  output logic               cnt_load,
  output logic [FIELD_W-1:0] cnt_val,
  output logic               addr_n,
  output logic               data_n,
  output logic               done,
  output logic               busy,
  output logic               wide
);
  phase_e             phase_q;
  logic [FIELD_W-1:0] access_q;
  logic [FIELD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      addr_n   <= 1'b1;
      data_n   <= 1'b1;
      done     <= 1'b0;
      wide     <= 1'b0;
      access_q <= '0;
      hold_q   <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req) begin
          phase_q  <= PH_SETUP;
          addr_n   <= 1'b0;
          access_q <= access_f;
          hold_q   <= hold_f;
          wide     <= wide_f;
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_ACCESS;
          data_n  <= 1'b0;
        end
        PH_ACCESS: if (cnt_zero) begin
          phase_q <= PH_HOLD;
          data_n  <= 1'b1;
        end
        PH_HOLD: if (cnt_zero) begin
          phase_q <= PH_DONE;
          addr_n  <= 1'b1;
          done    <= 1'b1;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase_q)
      PH_IDLE:   if (req)      begin cnt_load = 1'b1; cnt_val = setup_f;  end
      PH_SETUP:  if (cnt_zero) begin cnt_load = 1'b1; cnt_val = access_q; end
      PH_ACCESS: if (cnt_zero) begin cnt_load = 1'b1; cnt_val = hold_q;   end
      default: ;
    endcase
  end

  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq #(
  parameter int FIELD_W = 8,
  parameter int CFG_W   = 32,
  parameter int NSPACE  = 2,
  localparam int SEL_W  = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_space,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req,
  input  logic [SEL_W-1:0] req_space,
  output logic             addr_strobe_n,
  output logic             data_strobe_n,
  output logic             done,
  output logic             busy,
  output logic             xfer_wide
);
  logic [FIELD_W-1:0] setup_f, access_f, hold_f, cnt_val;
  logic               wide_f, cnt_load, cnt_zero;

  card_strobe_regs #(.FIELD_W(FIELD_W), .CFG_W(CFG_W), .NSPACE(NSPACE)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_space(cfg_space),
    .cfg_wdata(cfg_wdata), .rd_space(req_space),
    .setup_f(setup_f), .access_f(access_f), .hold_f(hold_f), .wide_f(wide_f)
  );

  card_phase_counter #(.W(FIELD_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  card_strobe_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk(clk), .rst(rst), .req(req),
    .setup_f(setup_f), .access_f(access_f), .hold_f(hold_f), .wide_f(wide_f),
    .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .addr_n(addr_strobe_n), .data_n(data_strobe_n), .done(done),
    .busy(busy), .wide(xfer_wide)
  );
endmodule

// File: rtl/card_strobe_checker.sv
module card_strobe_checker (
  input logic clk,
  input logic rst,
  input logic addr_strobe_n,
  input logic data_strobe_n,
  input logic done,
  input logic busy
);
  // R1: reset drives both strobes inactive and clears done
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (addr_strobe_n && data_strobe_n && !done));

  // R5: data strobe only inside an address strobe window
  a_r5_data_inside_addr: assert property (@(posedge clk) disable iff (rst)
    !data_strobe_n |-> !addr_strobe_n);

  // R5: address strobe already low in the cycle before data strobe falls
  a_r5_addr_before_data: assert property (@(posedge clk) disable iff (rst)
    $fell(data_strobe_n) |-> $past(!addr_strobe_n));

  // R5: data strobe already high in the cycle before address strobe rises
  a_r5_data_release_first: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_strobe_n) |-> $past(data_strobe_n));

  // R6: done marks the address strobe release
  a_r6_done_with_release: assert property (@(posedge clk) disable iff (rst)
    done |-> ($rose(addr_strobe_n)));

  // R6: done lasts one cycle and the block is idle afterwards
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

bind card_strobe_seq card_strobe_checker u_chk (
  .clk(clk), .rst(rst), .addr_strobe_n(addr_strobe_n),
  .data_strobe_n(data_strobe_n), .done(done), .busy(busy)
);

// File: tb/card_strobe_seq_bench.sv
module card_strobe_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int s;
    int a;
    int h;
    int w;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_space = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic [0:0]  req_space = '0;
  logic        addr_strobe_n, data_strobe_n, done, busy, xfer_wide;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_strobe_seq u_card_strobe_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_space(cfg_space),
    .cfg_wdata(cfg_wdata), .req(req), .req_space(req_space),
    .addr_strobe_n(addr_strobe_n), .data_strobe_n(data_strobe_n),
    .done(done), .busy(busy), .xfer_wide(xfer_wide)
  );

  task automatic check(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int s, input int a, input int h,
                                     input int w, input int junk);
    mk = {w[0], junk[6:0], h[7:0], a[7:0], s[7:0]};
  endfunction

  task automatic write_cfg(input int sp, input logic [31:0] word);
    @(negedge clk);
    cfg_we = 1'b1; cfg_space = sp[0:0]; cfg_wdata = word;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_req(input int sp, input int s, input int a, input int h, input int w);
    exp_t e;
    e.s = s + 1; e.a = a + 1; e.h = h + 1; e.w = w;
    @(negedge clk);
    exp_q.push_back(e);
    req = 1'b1; req_space = sp[0:0];
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic run(input int sp, input int s, input int a, input int h, input int w);
    start_req(sp, s, a, h, w);
    wait_done();
  endtask

  // monitor: measure phase lengths at falling edges, compare with queue
  int stage = 0;
  int s_cnt = 0, a_cnt = 0, h_cnt = 0, w_seen = 0;
  bit idle_chk = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (idle_chk) begin
        idle_chk = 0;
        check(busy == 1'b0, "R6 busy low after done", busy, 0);
      end
      if (done && !(stage == 3 && addr_strobe_n))
        check(0, "R6 done outside release cycle", 1, 0);
      case (stage)
        0: if (!addr_strobe_n) begin
             stage = 1; s_cnt = 1; w_seen = xfer_wide;
             if (exp_q.size() == 0) check(0, "R9 access with no request pending", 1, 0);
             if (!data_strobe_n) check(0, "R5 data strobe with address strobe", 0, 1);
           end else if (!data_strobe_n) begin
             check(0, "R5 data strobe outside address strobe", 0, 1);
           end
        1: if (addr_strobe_n) begin
             check(0, "R5 address released during setup", 1, 0); stage = 0;
           end else if (!data_strobe_n) begin
             stage = 2; a_cnt = 1;
           end else s_cnt++;
        2: if (addr_strobe_n) begin
             check(0, "R5 address released during access", 1, 0); stage = 0;
           end else if (data_strobe_n) begin
             stage = 3; h_cnt = 1;
           end else a_cnt++;
        default: if (!data_strobe_n) begin
             check(0, "R5 data strobe reasserted in hold", 0, 1); stage = 0;
           end else if (addr_strobe_n) begin
             stage = 0; idle_chk = 1;
             check(done == 1'b1, "R6 done with address release", done, 1);
             if (exp_q.size() != 0) begin
               exp_t e;
               e = exp_q.pop_front();
               check(s_cnt == e.s, "R2 setup length", s_cnt, e.s);
               check(a_cnt == e.a, "R3 access length", a_cnt, e.a);
               check(h_cnt == e.h, "R4 hold length", h_cnt, e.h);
               check(w_seen == e.w, "R8 width bit", w_seen, e.w);
             end
           end else h_cnt++;
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at ports
    check(addr_strobe_n == 1'b1, "R1 address strobe idle", addr_strobe_n, 1);
    check(data_strobe_n == 1'b1, "R1 data strobe idle", data_strobe_n, 1);
    check(done == 1'b0, "R1 done low", done, 0);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    check(xfer_wide == 1'b0, "R1 width low", xfer_wide, 0);
    // R1: zero configuration in both spaces -> 1/1/1
    run(0, 0, 0, 0, 0);
    run(1, 0, 0, 0, 0);
    // R2 R3 R4: common space timing
    write_cfg(0, mk(8'h25, 8'h10, 8'h0C, 0, 0));
    run(0, 8'h25, 8'h10, 8'h0C, 0);
    // R7 R8 R11: I/O space with reserved bits set
    write_cfg(1, mk(2, 5, 3, 1, 7'h55));
    run(1, 2, 5, 3, 1);
    run(0, 8'h25, 8'h10, 8'h0C, 0);
    // boundary: largest fields
    write_cfg(0, mk(255, 255, 255, 1, 0));
    run(0, 255, 255, 255, 1);
    // R10: rewrite the active word mid-access
    start_req(1, 2, 5, 3, 1);
    repeat (2) @(negedge clk);
    write_cfg(1, mk(9, 9, 9, 0, 0));
    wait_done();
    run(1, 9, 9, 9, 0);
    // R9: request while busy is ignored
    write_cfg(0, mk(7, 1, 0, 0, 0));
    start_req(0, 7, 1, 0, 0);
    repeat (3) @(negedge clk);
    req = 1'b1; req_space = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    begin
      int lows = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!addr_strobe_n || busy) lows++;
      end
      check(lows == 0, "R9 no access after ignored request", lows, 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule